// File: doc/BRIEF.md
# Radix-2 Montgomery Modular Multiplier

This block computes the Montgomery product of two binary operands: given A, B and an odd modulus N, all K bits wide, it returns a value congruent to A·B·2^-K modulo N. A single pulse on `start` captures the operands. The block stays busy for a data-dependent number of cycles and then presents the product on `result` with a one-cycle `done` pulse. The result is only partly reduced: it lies in [0, 2N), so a caller that needs a fully reduced value subtracts N once.

Inside, the running value is held as a sum/carry vector pair. Every update passes through one shared row of carry-save cells, so no carry ever ripples across the word. The row has two configurations. In three-input form it acts as a row of full adders and runs the per-bit loop iterations. In two-input form it acts as two half-adder stages in series, and the block uses that form twice: first to compute B+N before the loop, and then to merge the final sum/carry pair into one binary word after the loop. Each of these phases repeats until the carry vector is zero.

Some loop iterations would add nothing. This happens when the current bit of A is zero and the low bits of both vectors are zero. The block recognises such iterations from register bits alone and performs them as a plain shift, without using the adder. When two of them come in a row, both are retired in a single cycle.

Top module: `mont_mul_r2`

## Requirements
- R1: After `done`, `result` (K+1 bits) is congruent to A·B·2^-K mod N and is strictly less than 2N. This holds for any odd N and any A < N, B < N.
- R2: `done` is high for exactly one cycle per accepted operation. `busy` is high from the cycle after `start` is accepted until the cycle in which `done` rises, where `busy` is low again.
- R3: Operands are captured in the cycle `start` is seen while idle. A `start` pulse, or any change of the operand inputs, while `busy` is high has no effect on the result.
- R4: A loop iteration whose A bit is zero, and whose sum and carry vectors both have bit 0 equal to zero, is a pure right shift with no adder use. Two such iterations in a row retire in one cycle. For A = 0 and B = 0 the latency from the accepting edge to the edge that raises `done` is K/2+3 edges, counting both ends.
- R5: Every loop iteration that uses the adder selects its addend from {0, B, N, B+N} by the pair (A bit, quotient bit). The quotient bit is chosen so that the new sum is even. As a result, no information is lost by the right shift.
- R6: After reset, `busy` and `done` are 0 and `result` is 0.
- R7: Precomputation of B+N and the final conversion each apply two half-adder stages per cycle. Each phase ends in the cycle the produced carry vector is zero. For A = 0, B = 1, N = 3, the precomputation takes two cycles and the total latency is K/2+4 edges.
- R8: The conversion's output always fits in K+1 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation when idle |
| op_a | input | K | Multiplier operand A |
| op_b | input | K | Multiplicand operand B |
| modulus | input | K | Odd modulus N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | K+1 | Montgomery product, in [0, 2N) |

## Verification
The assertions check several properties on every cycle:
- Each half-adder step during precomputation and conversion preserves the sum of the two vectors.
- Every adder-based loop step yields an even sum.
- A skipped iteration would have had a zero addend.
- The result lies below 2N and fits its width when `done` rises.
- `done` never lasts two cycles.

Only the bench's scenarios can show the properties that depend on a whole operation:
- that the product is congruent to the reference value for chosen operands;
- that a mid-run `start` leaves the answer untouched;
- that the skip logic and the two-stage mode produce the exact cycle counts stated for particular operands.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_LOOP = 2'd2,
    ST_CONV = 2'd3
  } mm_state_e;

  typedef enum logic {
    CSA_FULL  = 1'b0,
    CSA_HALF2 = 1'b1
  } csa_mode_e;

endpackage

// File: rtl/mm_csa_row.sv
module mm_csa_row
  import mm_pkg::*;
#(
  parameter int W = 34
) (
  input  csa_mode_e      mode,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  input  logic [W-1:0]   z,
  output logic [W-1:0]   sum,
  output logic [W-1:0]   carry
);

  // first-stage half-adder sums, shared by both configurations
  logic [W-1:0] hs;
  logic [W-1:0] f_sum, f_cry, h_sum, h_cry;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign hs[i]    = x[i] ^ y[i];
      assign f_sum[i] = hs[i] ^ z[i];
      if (i == 0) begin : g_lsb
        assign h_sum[i] = hs[i];
        assign f_cry[i] = 1'b0;
        assign h_cry[i] = 1'b0;
      end else begin : g_upper
        // second half-adder stage takes the generate bit of the neighbour
        assign h_sum[i] = hs[i] ^ (x[i-1] & y[i-1]);
        assign f_cry[i] = (x[i-1] & y[i-1]) | (hs[i-1] & z[i-1]);
        if (i == 1) begin : g_b1
          assign h_cry[i] = 1'b0;
        end else begin : g_bn
          assign h_cry[i] = hs[i-1] & (x[i-2] & y[i-2]);
        end
      end
    end
  endgenerate

  always_comb begin
    if (mode == CSA_FULL) begin
      sum   = f_sum;
      carry = f_cry;
    end else begin
      sum   = h_sum;
      carry = h_cry;
    end
  end

endmodule

// File: rtl/mm_skip_detect.sv
module mm_skip_detect (
  input  logic       a_bit0,
  input  logic       a_bit1,
  input  logic [1:0] s_low,
  input  logic [1:0] c_low,
  input  logic       two_left,
  output logic       skip1,
  output logic       skip2
);

  // decision uses register bits only, so it sits beside the adder, not after it
  always_comb begin
    skip1 = !a_bit0 && (s_low[0] == 1'b0) && (c_low[0] == 1'b0);
    skip2 = skip1 && two_left && !a_bit1 &&
            (s_low[1] == 1'b0) && (c_low[1] == 1'b0);
  end

endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int K = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chain_clear,
  input  logic              skip2,
  output mm_state_e         st,
  output logic              two_left,
  output logic              busy,
  output logic              done
);

  localparam int IW = $clog2(K + 1) + 1;

  mm_state_e      st_q, st_n;
  logic [IW-1:0]  idx_q, idx_n;
  logic           done_q, done_n;

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    done_n = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n  = ST_PRE;
          idx_n = '0;
        end
      end
      ST_PRE: begin
        if (chain_clear) st_n = ST_LOOP;
      end
      ST_LOOP: begin
        idx_n = idx_q + (skip2 ? IW'(2) : IW'(1));
        if (idx_n >= IW'(K)) st_n = ST_CONV;
      end
      ST_CONV: begin
        if (chain_clear) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      done_q <= done_n;
    end
  end

  assign st       = st_q;
  assign two_left = (idx_q + IW'(1)) < IW'(K);
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;

  // R2: the completion flag never stays high into a second cycle
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4: the bit index never runs past the operand width
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(K));

endmodule

// File: rtl/mont_mul_r2.sv
module mont_mul_r2
  import mm_pkg::*;
#(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] op_a,
  input  logic [K-1:0] op_b,
  input  logic [K-1:0] modulus,
  output logic         busy,
  output logic         done,
  output logic [K:0]   result
);

  localparam int W = K + 2;

  mm_state_e    st;
  csa_mode_e    mode;
  logic         two_left, skip1, skip2, chain_clear, q_bit, load, en;
  logic [K-1:0] a_sh, a_n, b_q, b_n, n_q, n_n;
  logic [W-1:0] bn_q, bn_n, s_q, s_n, c_q, c_n;
  logic [W-1:0] addend, csa_s, csa_c;
  logic [K:0]   res_q, res_n;

  mm_ctrl #(.K(K)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .chain_clear (chain_clear),
    .skip2       (skip2),
    .st          (st),
    .two_left    (two_left),
    .busy        (busy),
    .done        (done)
  );

  mm_skip_detect u_skip (
    .a_bit0   (a_sh[0]),
    .a_bit1   (a_sh[1]),
    .s_low    (s_q[1:0]),
    .c_low    (c_q[1:0]),
    .two_left (two_left),
    .skip1    (skip1),
    .skip2    (skip2)
  );

  // quotient bit: makes the low bit of the three-input sum zero
  assign q_bit = s_q[0] ^ c_q[0] ^ (a_sh[0] & b_q[0]);

  always_comb begin
    case ({a_sh[0], q_bit})
      2'b00:   addend = '0;
      2'b10:   addend = {2'b00, b_q};
      2'b01:   addend = {2'b00, n_q};
      default: addend = bn_q;
    endcase
  end

  assign mode = (st == ST_LOOP) ? CSA_FULL : CSA_HALF2;

  mm_csa_row #(.W(W)) u_csa (
    .mode  (mode),
    .x     (s_q),
    .y     (c_q),
    .z     (addend),
    .sum   (csa_s),
    .carry (csa_c)
  );

  assign chain_clear = (csa_c == '0);
  assign load        = (st == ST_IDLE) && start;
  assign en          = (st != ST_IDLE) || load;

  always_comb begin
    a_n   = a_sh;
    b_n   = b_q;
    n_n   = n_q;
    bn_n  = bn_q;
    s_n   = s_q;
    c_n   = c_q;
    res_n = res_q;
    case (st)
      ST_IDLE: begin
        if (start) begin
          a_n = op_a;
          b_n = op_b;
          n_n = modulus;
          s_n = {2'b00, op_b};
          c_n = {2'b00, modulus};
        end
      end
      ST_PRE: begin
        s_n = csa_s;
        c_n = csa_c;
        if (chain_clear) begin
          bn_n = csa_s;
          s_n  = '0;
          c_n  = '0;
        end
      end
      ST_LOOP: begin
        if (skip2) begin
          s_n = s_q >> 2;
          c_n = c_q >> 2;
          a_n = a_sh >> 2;
        end else if (skip1) begin
          s_n = s_q >> 1;
          c_n = c_q >> 1;
          a_n = a_sh >> 1;
        end else begin
          s_n = csa_s >> 1;
          c_n = csa_c >> 1;
          a_n = a_sh >> 1;
        end
      end
      ST_CONV: begin
        s_n = csa_s;
        c_n = csa_c;
        if (chain_clear) res_n = csa_s[K:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh  <= '0;
      b_q   <= '0;
      n_q   <= '0;
      bn_q  <= '0;
      s_q   <= '0;
      c_q   <= '0;
      res_q <= '0;
    end else if (en) begin
      a_sh  <= a_n;
      b_q   <= b_n;
      n_q   <= n_n;
      bn_q  <= bn_n;
      s_q   <= s_n;
      c_q   <= c_n;
      res_q <= res_n;
    end
  end

  assign result = res_q;

  // R7: a two-stage half-add step keeps the value of the vector pair
  p_half_keeps_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE || st == ST_CONV) |->
      (({1'b0, csa_s} + {1'b0, csa_c}) == ({1'b0, s_q} + {1'b0, c_q})));

  // R5: an adder-based loop step always produces an even sum
  p_loop_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOOP && !skip1) |-> (csa_s[0] == 1'b0));

  // R4: a skipped iteration would have added zero
  p_skip_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOOP && skip1) |-> (addend == '0));

  // R8: the merged word fits K+1 bits
  p_conv_fit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONV && chain_clear) |-> (csa_s[W-1] == 1'b0));

  // R1: the presented result lies below twice the modulus
  p_result_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, res_q} < {n_q, 1'b0}));

  // R3: captured operands hold while an operation runs
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(b_q) && $stable(n_q)));

endmodule

// File: tb/tb_mont_mul_r2.sv
module tb_mont_mul_r2;

  localparam int K = 32;

  logic         clk, rst_n, start;
  logic [K-1:0] op_a, op_b, modulus;
  logic         busy, done;
  logic [K:0]   result;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  mont_mul_r2 #(.K(K)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .modulus (modulus),
    .busy    (busy),
    .done    (done),
    .result  (result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [127:0] mont_ref(input logic [K-1:0] a, b, n);
    logic [127:0] r;
    r = ({96'd0, a} * {96'd0, b}) % {96'd0, n};
    for (int i = 0; i < K; i++) begin
      if (r[0]) r = r + {96'd0, n};
      r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [K-1:0] a, b, n,
                        output logic [K:0] r, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; modulus = n; start = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    r = result;
  endtask

  task automatic check_product(input logic [K-1:0] a, b, n, input string tag);
    logic [K:0]   r;
    int           lat;
    logic [127:0] exp, got;
    run_op(a, b, n, r, lat);
    exp = mont_ref(a, b, n);
    got = {95'd0, r} % {96'd0, n};
    check(got == exp, {tag, " R1 congruence"}, got, exp);
    check({95'd0, r} < {95'd0, n, 1'b0}, {tag, " R1 below 2N"}, {95'd0, r}, {95'd0, n, 1'b0});
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R6 busy after reset", busy, 0);
    check(done == 1'b0, "R6 done after reset", done, 0);
    check(result == '0, "R6 result after reset", result, 0);
  endtask

  task automatic t_zero_skip;
    logic [K:0] r;
    int lat;
    run_op('0, '0, 32'd12345, r, lat);
    check(r == '0, "R4 zero product", r, 0);
    check(lat == K/2 + 3, "R4 latency with all-zero A", lat, K/2 + 3);
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", done, 0);
  endtask

  task automatic t_half_mode;
    logic [K:0] r;
    int lat;
    run_op('0, 32'd1, 32'd3, r, lat);
    check(r == '0, "R7 zero product", r, 0);
    check(lat == K/2 + 4, "R7 two-cycle precompute latency", lat, K/2 + 4);
  endtask

  task automatic t_vectors;
    check_product(32'h1234_5678, 32'h0ABC_DEF1, 32'h8000_0001, "R5 mixed");
    check_product(32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R8 max modulus");
    check_product(32'hFFFF_0000, 32'h0000_0001, 32'hF123_4567, "R5 sparse A");
    check_product(32'h0000_0001, 32'h0000_0001, 32'h0000_0007, "R1 small");
    check_product(32'hAAAA_AAAA, 32'h5555_5555, 32'hC000_0003, "R5 alternating");
    check_product(32'h0000_0000, 32'h0000_0000, 32'h0000_0001, "R1 unit modulus");
  endtask

  task automatic t_busy_start;
    logic [127:0] exp, got;
    @(negedge clk);
    op_a = 32'h0F0F_1234; op_b = 32'h7777_0001; modulus = 32'hFEDC_BA99; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    @(negedge clk);
    @(negedge clk);
    op_a = 32'h1; op_b = 32'h2; modulus = 32'h5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R2 busy low at done", busy, 0);
    exp = mont_ref(32'h0F0F_1234, 32'h7777_0001, 32'hFEDC_BA99);
    got = {95'd0, result} % 128'hFEDC_BA99;
    check(got == exp, "R3 start ignored while busy", got, exp);
    @(negedge clk);
    check(busy == 1'b0, "R3 no second run", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0; modulus = 32'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_zero_skip;
    t_half_mode;
    t_vectors;
    t_busy_start;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule